// File: doc/BRIEF.md
# Bit Manipulation Execution Unit

This unit executes one bit-manipulation operation per cycle on a 64-bit datapath. A caller presents two operands, a five-bit operation code, a small immediate and a flag that selects whether shift amounts and bit indices come from that immediate or from the second operand. It also raises a valid strobe. One clock edge later the result appears on a registered output, together with a valid bit.

The operations fall into four groups:

- **Scaled index-plus-base additions.**
- **Counting and compare operations:** zero counts, population count, rotates, minimum and maximum, and narrow sign extension.
- **Carry-less multiplication:** returns either half of the 128-bit product.
- **Single-bit operations:** set, clear, invert or extract one addressed bit.

Instruction decode and word-sized variants are handled elsewhere. The unit only sees a resolved operation code.

Top module: `bitmanip_alu`

## Requirements
- R1: After synchronous reset, `out_valid` and `result` are 0. Each cycle, `out_valid` takes the value `in_valid` had on the previous edge. `result` loads a new value only on an edge where `in_valid` is 1, and holds otherwise.
- R2: Codes 0, 1 and 2 return `src_a` shifted left by 1, 2 or 3, plus `src_b`, modulo 2^64.
- R3: Code 3 returns the number of zero bits above the highest set bit of `src_a`. Code 4 returns the number of zero bits below the lowest set bit. Both return 64 when `src_a` is 0, and 0x1000 gives a leading count of 51.
- R4: Code 5 returns the number of set bits in `src_a`.
- R5: Codes 6 and 7 rotate `src_a` left or right. The amount is `imm` when `use_imm` is 1, and otherwise bits [5:0] of `src_b`. Rotating 0x12345678 right by 4 gives 0x8000000001234567.
- R6: Codes 8 and 9 return the signed minimum and maximum of the two operands. Codes 10 and 11 return the unsigned minimum and maximum.
- R7: Code 12 sign-extends bits [7:0] of `src_a` to 64 bits. Code 13 sign-extends bits [15:0].
- R8: Code 14 returns bits [63:0] of the carry-less product of `src_a` and `src_b`, where partial products are combined by XOR. Code 15 returns bits [127:64].
- R9: Codes 16, 17 and 18 set, clear or invert one bit of `src_a`. Code 19 returns that bit in bit 0, with zeros above. The bit index is chosen the same way as the rotate amount in R5.
- R10: Codes 20 to 31 return 0.
- R11: The immediate and `use_imm` have no effect on operations other than rotates and single-bit operations.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operation request strobe |
| op | input | 5 | Operation code |
| use_imm | input | 1 | Take amount or index from `imm` |
| imm | input | 6 | Immediate amount or bit index |
| src_a | input | 64 | First operand |
| src_b | input | 64 | Second operand |
| out_valid | output | 1 | Result valid, one cycle after request |
| result | output | 64 | Registered result |

## Verification
The only state is the output register, its valid bit and the hold-on-idle behaviour. A wrong state therefore shows up at the ports one edge after the offending request: as a missing or extra `out_valid`, or as a result that changed while the unit was idle. A fault inside a functional group, such as a dropped partial product or a miscounted edge case, shows up in the very next result of that operation. The bench sweeps every code with fixed corner operands and a pseudo-random stream, in both amount-source modes. This makes each such fault visible within a few requests.

// File: rtl/bitmanip_pkg.sv
package bitmanip_pkg;

    localparam int DATA_W = 64;

    typedef enum logic [4:0] {
        OP_SHADD1 = 5'd0,
        OP_SHADD2 = 5'd1,
        OP_SHADD3 = 5'd2,
        OP_LZCNT  = 5'd3,
        OP_TZCNT  = 5'd4,
        OP_POPCNT = 5'd5,
        OP_ROTL   = 5'd6,
        OP_ROTR   = 5'd7,
        OP_SMIN   = 5'd8,
        OP_SMAX   = 5'd9,
        OP_UMIN   = 5'd10,
        OP_UMAX   = 5'd11,
        OP_SEXT8  = 5'd12,
        OP_SEXT16 = 5'd13,
        OP_XMULLO = 5'd14,
        OP_XMULHI = 5'd15,
        OP_BITSET = 5'd16,
        OP_BITCLR = 5'd17,
        OP_BITFLP = 5'd18,
        OP_BITGET = 5'd19
    } bm_op_e;

    function automatic logic [DATA_W-1:0] sext_from(input logic [DATA_W-1:0] v,
                                                    input int unsigned      nbits);
        logic [DATA_W-1:0] r;
        for (int i = 0; i < DATA_W; i++) begin
            r[i] = (i < int'(nbits)) ? v[i] : v[nbits-1];
        end
        return r;
    endfunction

endpackage

// File: rtl/bitmanip_count.sv
module bitmanip_count #(
    parameter int XLEN = 64,
    localparam int CW  = $clog2(XLEN) + 1
) (
    input  logic [XLEN-1:0] val,
    output logic [CW-1:0]   lead_zeros,
    output logic [CW-1:0]   trail_zeros,
    output logic [CW-1:0]   ones
);
    always_comb begin
        lead_zeros  = CW'(XLEN);
        trail_zeros = CW'(XLEN);
        ones        = '0;
        for (int i = 0; i < XLEN; i++) begin
            if (val[i]) lead_zeros = CW'(XLEN - 1 - i);
            ones = ones + CW'(val[i]);
        end
        for (int j = XLEN - 1; j >= 0; j--) begin
            if (val[j]) trail_zeros = CW'(j);
        end
    end
endmodule

// File: rtl/bitmanip_clmul.sv
module bitmanip_clmul #(
    parameter int XLEN = 64
) (
    input  logic [XLEN-1:0] mcand,
    input  logic [XLEN-1:0] mplier,
    output logic [XLEN-1:0] prod_lo,
    output logic [XLEN-1:0] prod_hi
);
    logic [2*XLEN-1:0] acc;

    always_comb begin
        acc = '0;
        for (int i = 0; i < XLEN; i++) begin
            if (mplier[i]) acc = acc ^ ({{XLEN{1'b0}}, mcand} << i);
        end
    end

    assign prod_lo = acc[XLEN-1:0];
    assign prod_hi = acc[2*XLEN-1:XLEN];
endmodule

// File: rtl/bitmanip_bits.sv
module bitmanip_bits #(
    parameter int XLEN = 64,
    localparam int SW  = $clog2(XLEN)
) (
    input  logic [XLEN-1:0] val,
    input  logic [SW-1:0]   sel,
    output logic [XLEN-1:0] rot_l,
    output logic [XLEN-1:0] rot_r,
    output logic [XLEN-1:0] with_set,
    output logic [XLEN-1:0] with_clr,
    output logic [XLEN-1:0] with_flip,
    output logic [XLEN-1:0] picked
);
    logic [XLEN-1:0]   onehot;
    logic [2*XLEN-1:0] dbl_l;
    logic [2*XLEN-1:0] dbl_r;

    assign onehot = {{(XLEN-1){1'b0}}, 1'b1} << sel;
    assign dbl_l  = {val, val} << sel;
    assign dbl_r  = {val, val} >> sel;

    assign rot_l     = dbl_l[2*XLEN-1:XLEN];
    assign rot_r     = dbl_r[XLEN-1:0];
    assign with_set  = val | onehot;
    assign with_clr  = val & ~onehot;
    assign with_flip = val ^ onehot;
    assign picked    = {{(XLEN-1){1'b0}}, val[sel]};
endmodule

// File: rtl/bitmanip_alu.sv
module bitmanip_alu
    import bitmanip_pkg::*;
#(
    parameter int XLEN = DATA_W,
    localparam int SW  = $clog2(XLEN),
    localparam int CW  = SW + 1
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            in_valid,
    input  logic [4:0]      op,
    input  logic            use_imm,
    input  logic [SW-1:0]   imm,
    input  logic [XLEN-1:0] src_a,
    input  logic [XLEN-1:0] src_b,
    output logic            out_valid,
    output logic [XLEN-1:0] result
);
    bm_op_e          op_e;
    logic [SW-1:0]   amt;
    logic [CW-1:0]   n_lead, n_trail, n_ones;
    logic [XLEN-1:0] xm_lo, xm_hi;
    logic [XLEN-1:0] r_l, r_r, b_set, b_clr, b_flp, b_get;
    logic            a_lt_b_s, a_lt_b_u;
    logic [XLEN-1:0] next_res;

    assign op_e = bm_op_e'(op);
    assign amt  = use_imm ? imm : src_b[SW-1:0];

    bitmanip_count #(.XLEN(XLEN)) u_count (
        .val(src_a), .lead_zeros(n_lead), .trail_zeros(n_trail), .ones(n_ones)
    );

    bitmanip_clmul #(.XLEN(XLEN)) u_clmul (
        .mcand(src_a), .mplier(src_b), .prod_lo(xm_lo), .prod_hi(xm_hi)
    );

    bitmanip_bits #(.XLEN(XLEN)) u_bits (
        .val(src_a), .sel(amt), .rot_l(r_l), .rot_r(r_r),
        .with_set(b_set), .with_clr(b_clr), .with_flip(b_flp), .picked(b_get)
    );

    assign a_lt_b_s = $signed(src_a) < $signed(src_b);
    assign a_lt_b_u = src_a < src_b;

    always_comb begin
        unique case (op_e)
            OP_SHADD1: next_res = (src_a << 1) + src_b;
            OP_SHADD2: next_res = (src_a << 2) + src_b;
            OP_SHADD3: next_res = (src_a << 3) + src_b;
            OP_LZCNT:  next_res = XLEN'(n_lead);
            OP_TZCNT:  next_res = XLEN'(n_trail);
            OP_POPCNT: next_res = XLEN'(n_ones);
            OP_ROTL:   next_res = r_l;
            OP_ROTR:   next_res = r_r;
            OP_SMIN:   next_res = a_lt_b_s ? src_a : src_b;
            OP_SMAX:   next_res = a_lt_b_s ? src_b : src_a;
            OP_UMIN:   next_res = a_lt_b_u ? src_a : src_b;
            OP_UMAX:   next_res = a_lt_b_u ? src_b : src_a;
            OP_SEXT8:  next_res = sext_from(src_a, 8);
            OP_SEXT16: next_res = sext_from(src_a, 16);
            OP_XMULLO: next_res = xm_lo;
            OP_XMULHI: next_res = xm_hi;
            OP_BITSET: next_res = b_set;
            OP_BITCLR: next_res = b_clr;
            OP_BITFLP: next_res = b_flp;
            OP_BITGET: next_res = b_get;
            default:   next_res = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            result    <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) result <= next_res;
        end
    end

    // R1: the valid bit follows the request one edge later
    p_valid_follows_r1: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);
    p_idle_follows_r1: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> (!out_valid && $stable(result)));

    // R3: zero counts of an all-zero operand saturate at the width
    p_zero_count_r3: assert property (@(posedge clk) disable iff (rst)
        (in_valid && (op == 5'd3 || op == 5'd4) && src_a == '0) |=> result == XLEN);

    // R4: population count never exceeds the width
    p_pop_bound_r4: assert property (@(posedge clk) disable iff (rst)
        (in_valid && op == 5'd5) |=> result <= XLEN);

    // R6: unsigned minimum is one of the inputs and not above either
    p_umin_r6: assert property (@(posedge clk) disable iff (rst)
        (in_valid && op == 5'd10) |=>
            (result <= $past(src_a) && result <= $past(src_b) &&
             (result == $past(src_a) || result == $past(src_b))));

    // R7: byte extension leaves the upper bits all equal
    p_sext_upper_r7: assert property (@(posedge clk) disable iff (rst)
        (in_valid && op == 5'd12) |=>
            (result[XLEN-1:7] == '0 || result[XLEN-1:7] == '1));

    // R9: single-bit edits change exactly one bit, extraction leaves one bit
    p_flip_one_r9: assert property (@(posedge clk) disable iff (rst)
        (in_valid && op == 5'd18) |=> $countones(result ^ $past(src_a)) == 1);
    p_get_narrow_r9: assert property (@(posedge clk) disable iff (rst)
        (in_valid && op == 5'd19) |=> result[XLEN-1:1] == '0);

    // R10: unassigned codes produce zero
    p_undef_zero_r10: assert property (@(posedge clk) disable iff (rst)
        (in_valid && op >= 5'd20) |=> result == '0);
endmodule

// File: tb/bitmanip_alu_bench.sv
module bitmanip_alu_bench;
    logic        clk = 1'b0;
    logic        rst;
    logic        in_valid;
    logic [4:0]  op;
    logic        use_imm;
    logic [5:0]  imm;
    logic [63:0] src_a, src_b;
    logic        out_valid;
    logic [63:0] result;

    int checks = 0;
    int errors = 0;
    logic [63:0] lfsr = 64'hACE1_2468_BDF1_3579;

    always #2 clk = ~clk;

    bitmanip_alu u_bitmanip_alu (
        .clk(clk), .rst(rst), .in_valid(in_valid), .op(op), .use_imm(use_imm),
        .imm(imm), .src_a(src_a), .src_b(src_b), .out_valid(out_valid), .result(result)
    );

    function automatic logic [63:0] expect_of(input logic [4:0] c, input logic [63:0] a,
                                              input logic [63:0] b, input logic ui,
                                              input logic [5:0] im);
        int unsigned k = ui ? im : b[5:0];
        logic [127:0] p = '0;
        int n = 0;
        case (c)
            5'd0: return a * 2 + b;
            5'd1: return a * 4 + b;
            5'd2: return a * 8 + b;
            5'd3: begin
                for (int i = 63; i >= 0; i--) begin
                    if (a[i]) return 64'(63 - i);
                end
                return 64;
            end
            5'd4: begin
                for (int i = 0; i < 64; i++) begin
                    if (a[i]) return 64'(i);
                end
                return 64;
            end
            5'd5: begin
                for (int i = 0; i < 64; i++) n += a[i];
                return 64'(n);
            end
            5'd6: return (k == 0) ? a : ((a << k) | (a >> (64 - k)));
            5'd7: return (k == 0) ? a : ((a >> k) | (a << (64 - k)));
            5'd8: return ($signed(a) <= $signed(b)) ? a : b;
            5'd9: return ($signed(a) >= $signed(b)) ? a : b;
            5'd10: return (a <= b) ? a : b;
            5'd11: return (a >= b) ? a : b;
            5'd12: return {{56{a[7]}}, a[7:0]};
            5'd13: return {{48{a[15]}}, a[15:0]};
            5'd14, 5'd15: begin
                for (int i = 0; i < 64; i++) begin
                    if (b[i]) p = p ^ (128'(a) << i);
                end
                return (c == 5'd14) ? p[63:0] : p[127:64];
            end
            5'd16: return a | (64'd1 << k);
            5'd17: return a & ~(64'd1 << k);
            5'd18: return a ^ (64'd1 << k);
            5'd19: return (a >> k) & 64'd1;
            default: return 64'd0;
        endcase
    endfunction

    function automatic string tag_of(input logic [4:0] c);
        if (c <= 2) return "R2";
        if (c <= 4) return "R3";
        if (c == 5) return "R4";
        if (c <= 7) return "R5";
        if (c <= 11) return "R6";
        if (c <= 13) return "R7";
        if (c <= 15) return "R8";
        if (c <= 19) return "R9";
        return "R10";
    endfunction

    task automatic check(input string tag, input logic [63:0] got, input logic [63:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic issue(input logic [4:0] c, input logic [63:0] a, input logic [63:0] b,
                         input logic ui, input logic [5:0] im, input string tag);
        @(negedge clk);
        in_valid = 1'b1; op = c; src_a = a; src_b = b; use_imm = ui; imm = im;
        @(negedge clk);
        in_valid = 1'b0;
        check(tag, {63'd0, out_valid}, 64'd1);
        check(tag, result, expect_of(c, a, b, ui, im));
    endtask

    function automatic logic [63:0] step(input logic [63:0] s);
        return {s[62:0], s[63] ^ s[62] ^ s[60] ^ s[59]};
    endfunction

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [63:0] corner [8];
        logic [63:0] held;
        corner[0] = 64'd0;                  corner[1] = 64'hFFFF_FFFF_FFFF_FFFF;
        corner[2] = 64'h8000_0000_0000_0000; corner[3] = 64'd1;
        corner[4] = 64'h7FFF_FFFF_FFFF_FFFF; corner[5] = 64'h0000_0000_0000_8080;
        corner[6] = 64'h0000_0000_0000_1000; corner[7] = 64'h1234_5678_9ABC_DEF0;

        rst = 1'b1; in_valid = 1'b0; op = '0; use_imm = 1'b0; imm = '0;
        src_a = '0; src_b = '0;
        repeat (3) @(negedge clk);
        check("R1 reset valid", {63'd0, out_valid}, 64'd0);
        check("R1 reset result", result, 64'd0);
        rst = 1'b0;

        // directed corner values
        issue(5'd3, 64'h1000, 64'd0, 1'b0, 6'd0, "R3 lead 0x1000");
        check("R3 lead 0x1000 literal", result, 64'd51);
        issue(5'd7, 64'h1234_5678, 64'd4, 1'b0, 6'd0, "R5 rotr");
        check("R5 rotr literal", result, 64'h8000_0000_0123_4567);
        issue(5'd7, 64'h1234_5678, 64'hFFC0, 1'b1, 6'd4, "R5 rotr imm");
        check("R5 rotr imm literal", result, 64'h8000_0000_0123_4567);
        issue(5'd4, 64'd0, 64'd0, 1'b0, 6'd0, "R3 trail zero");
        check("R3 trail zero literal", result, 64'd64);
        issue(5'd19, 64'h8, 64'hFFFF_FFC3, 1'b0, 6'd0, "R9 index low bits");
        check("R9 index low bits literal", result, 64'd1);
        issue(5'd15, 64'h8000_0000_0000_0000, 64'h2, 1'b0, 6'd0, "R8 high half");
        check("R8 high half literal", result, 64'd1);

        // R11: immediate ignored for non-amount ops
        issue(5'd0, 64'd5, 64'd7, 1'b1, 6'd63, "R11 imm ignored shadd");
        check("R11 imm ignored literal", result, 64'd17);
        issue(5'd14, 64'h3, 64'h3, 1'b1, 6'd9, "R11 imm ignored clmul");
        check("R11 clmul literal", result, 64'd5);

        // sweep all codes over corner pairs
        for (int c = 0; c < 32; c++) begin
            for (int i = 0; i < 8; i++) begin
                issue(5'(c), corner[i], corner[(i + 3) % 8], 1'(i & 1), 6'(i * 9), tag_of(5'(c)));
            end
        end

        // pseudo-random sweep
        for (int n = 0; n < 120; n++) begin
            for (int c = 0; c < 21; c++) begin
                logic [63:0] a, b;
                lfsr = step(lfsr); a = lfsr;
                lfsr = step(lfsr); b = lfsr;
                issue(5'(c), a, b, lfsr[7], lfsr[13:8], tag_of(5'(c)));
            end
        end

        // R1: idle cycles hold result and drop valid
        issue(5'd5, 64'hF0F0, 64'd0, 1'b0, 6'd0, "R1 before hold");
        held = result;
        @(negedge clk);
        op = 5'd1; src_a = 64'h1111; src_b = 64'h2222;
        @(negedge clk);
        @(negedge clk);
        check("R1 idle valid", {63'd0, out_valid}, 64'd0);
        check("R1 idle hold", result, held);

        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        check("R1 re-reset result", result, 64'd0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule